// File: doc/BRIEF.md
# Measurement definition pattern matcher

Once per machine pulse, this block takes a beam pattern (a beam code and a vector of condition bits) and tests it against a table of measurement definitions. Each definition slot that takes part and whose conditions hold sets its own event bit in a broadcast word. The broadcast word is registered and leaves the block one clock after the pattern arrives, together with a copy of the pattern. Downstream receivers use each event bit to decide whether a sample belongs to that definition's acquisition buffer.

The lower slots are permanent system definitions, for example 1 Hz, 10 Hz, full rate, single shot and feedback. They take part in matching at all times. The remaining slots serve clients. Each client slot runs a small state machine with three states. In Idle the slot can be configured and takes no part in matching. In Armed it matches pulses and holds its configuration. In Retired its measurement is complete, its done flag is raised, and it can be configured again. A client slot moves through a fixed set of transitions:

- start: a control write with the go bit, accepted only when the measurement count is nonzero, moves the slot from Idle or Retired to Armed.
- finish: the match that completes the last averaging group moves the slot from Armed to Retired.
- clear: a control write without the go bit moves the slot from Retired to Idle.

Top module: `mdm_matcher`

## Requirements
- R1: `bcast_valid` is high for exactly the one cycle after each cycle with `pulse_valid` high. In that cycle `bcast_events[i]` is 1 exactly when slot i matched, and `bcast_code` and `bcast_bits` carry the pattern. When `bcast_valid` is low, all broadcast outputs are zero.
- R2: A slot matches only if its stored beam code equals `pulse_code`.
- R3: A slot matches only if every bit set in its inclusion mask is also set in `pulse_bits`.
- R4: A slot matches only if no bit set in its exclusion mask is set in `pulse_bits`.
- R5: Slots 0 to NUM_SYS-1 are system slots. They always take part in matching, always report `slot_go` 1 and `slot_done` 0, and accept configuration writes at any time. The control field has no effect on them.
- R6: A client slot in Idle or Retired never sets its event bit.
- R7: Write fields are selected by `wr_field`: 0 beam code, 1 inclusion mask, 2 exclusion mask, 3 measurement count, 4 average count, 5 control, where `wr_data[0]` is the go bit. Field codes 6 and 7 are ignored. Every write to an Armed client slot is ignored.
- R8: A go write to a client slot whose measurement count is 0 is ignored.
- R9: An Armed client slot retires after exactly (average count × measurement count) matches, with an average count of 0 treated as 1. The last match still sets its event bit. `slot_go` falls and `slot_done` rises in the same cycle in which that match is broadcast.
- R10: A go write to a Retired slot arms it again with fresh counts. A control write without the go bit moves a Retired slot to Idle and clears `slot_done`.
- R11: After reset, `bcast_valid` and `bcast_events` are 0, client slots are Idle with `slot_done` 0, and all configuration fields are 0.
- R12: A write whose `wr_slot` is NUM_SLOTS or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_slot | input | SLOT_W | Slot index of the write |
| wr_field | input | 3 | Field select of the write |
| wr_data | input | PAT_W | Write data |
| pulse_valid | input | 1 | A pattern is present this cycle |
| pulse_code | input | CODE_W | Beam code of the pattern |
| pulse_bits | input | PAT_W | Condition bits of the pattern |
| bcast_valid | output | 1 | Broadcast word strobe |
| bcast_code | output | CODE_W | Broadcast beam code |
| bcast_bits | output | PAT_W | Broadcast condition bits |
| bcast_events | output | NUM_SLOTS | One event bit per slot |
| slot_go | output | NUM_SLOTS | Slot takes part in matching |
| slot_done | output | NUM_SLOTS | Client slot has retired |

## Verification
The hardest situation to reach is the retire edge of a client slot: the final match of the final averaging group. It has to land correctly even when non-matching pulses and ignored writes arrive between matches. The stimulus sweeps every measurement count from 1 to 3 against every average count from 0 to 3, feeding pulses until one past the expected retire point. It also interleaves code changes, mismatching pulses and stop writes while a slot is Armed. Mask behaviour is swept over all pairs of 4-bit inclusion and exclusion masks against all 16 low patterns.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    typedef enum logic [2:0] {
        F_CODE = 3'd0,
        F_INCL = 3'd1,
        F_EXCL = 3'd2,
        F_MEAS = 3'd3,
        F_AVG  = 3'd4,
        F_CTRL = 3'd5
    } field_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } slot_state_e;

endpackage

// File: rtl/mdm_compare.sv
module mdm_compare #(
    parameter int PAT_W  = 32,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] cfg_code,
    input  logic [PAT_W-1:0]  cfg_incl,
    input  logic [PAT_W-1:0]  cfg_excl,
    input  logic [CODE_W-1:0] pat_code,
    input  logic [PAT_W-1:0]  pat_bits,
    output logic              match
);
    logic code_ok;
    logic incl_ok;
    logic excl_ok;

    assign code_ok = (cfg_code == pat_code);
    assign incl_ok = ((pat_bits & cfg_incl) == cfg_incl);
    assign excl_ok = ~|(pat_bits & cfg_excl);
    assign match   = code_ok & incl_ok & excl_ok;
endmodule

// File: rtl/mdm_slot.sv
module mdm_slot
    import mdm_pkg::*;
#(
    parameter int PAT_W  = 32,
    parameter int CODE_W = 5,
    parameter int CNT_W  = 12,
    parameter bit IS_SYS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [2:0]        wr_field,
    input  logic [PAT_W-1:0]  wr_data,
    input  logic              pulse,
    input  logic [CODE_W-1:0] pat_code,
    input  logic [PAT_W-1:0]  pat_bits,
    output logic              hit,
    output logic              go,
    output logic              done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    slot_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [PAT_W-1:0]  incl_q, excl_q;
    logic [CNT_W-1:0]  meas_q, avg_q;
    logic [CNT_W-1:0]  meas_left_q, avg_left_q;
    logic [CNT_W-1:0]  avg_eff;
    logic              match, participate, wr_ok;
    logic              start, stop, last;

    mdm_compare #(.PAT_W(PAT_W), .CODE_W(CODE_W)) u_cmp (
        .cfg_code (code_q),
        .cfg_incl (incl_q),
        .cfg_excl (excl_q),
        .pat_code (pat_code),
        .pat_bits (pat_bits),
        .match    (match)
    );

    assign participate = IS_SYS ? 1'b1 : (state_q == S_RUN);
    assign hit         = pulse & participate & match;
    assign wr_ok       = wr_sel & (state_q != S_RUN);
    assign avg_eff     = (avg_q == '0) ? ONE : avg_q;
    assign start = !IS_SYS && wr_ok && (wr_field == F_CTRL) && wr_data[0] && (meas_q != '0);
    assign stop  = !IS_SYS && wr_ok && (wr_field == F_CTRL) && !wr_data[0];
    assign last  = hit && (state_q == S_RUN) && (avg_left_q == ONE) && (meas_left_q == ONE);

    // Configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            incl_q <= '0;
            excl_q <= '0;
            meas_q <= '0;
            avg_q  <= '0;
        end else if (wr_ok) begin
            case (wr_field)
                F_CODE:  code_q <= wr_data[CODE_W-1:0];
                F_INCL:  incl_q <= wr_data;
                F_EXCL:  excl_q <= wr_data;
                F_MEAS:  meas_q <= wr_data[CNT_W-1:0];
                F_AVG:   avg_q  <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_RUN;
            S_RUN:  if (last)  state_d = S_DONE;
            S_DONE: begin
                if (start)     state_d = S_RUN;
                else if (stop) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Progress counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_left_q <= '0;
            avg_left_q  <= '0;
        end else if (start) begin
            meas_left_q <= meas_q;
            avg_left_q  <= avg_eff;
        end else if (hit && state_q == S_RUN) begin
            if (avg_left_q == ONE) begin
                avg_left_q  <= avg_eff;
                meas_left_q <= meas_left_q - ONE;
            end else begin
                avg_left_q <= avg_left_q - ONE;
            end
        end
    end

    // Outputs
    always_comb begin
        go   = IS_SYS | (state_q == S_RUN);
        done = (state_q == S_DONE);
    end

    a_r7_cfg_frozen_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |=> ($stable(code_q) && $stable(incl_q) && $stable(excl_q)
                                && $stable(meas_q) && $stable(avg_q)));

    a_r8_armed_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (meas_left_q != '0 && avg_left_q != '0));

    a_r9_retire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !hit) |=> (state_q == S_RUN));

    a_r10_done_only_via_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> (state_q != S_DONE));

    if (IS_SYS) begin : g_sys_chk
        a_r5_sys_never_retires: assert property (@(posedge clk) disable iff (!rst_n)
            state_q == S_IDLE);
    end
endmodule

// File: rtl/mdm_bcast_reg.sv
module mdm_bcast_reg #(
    parameter int PAT_W     = 32,
    parameter int CODE_W    = 5,
    parameter int NUM_SLOTS = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pulse,
    input  logic [CODE_W-1:0]    code_in,
    input  logic [PAT_W-1:0]     bits_in,
    input  logic [NUM_SLOTS-1:0] events_in,
    output logic                 valid_out,
    output logic [CODE_W-1:0]    code_out,
    output logic [PAT_W-1:0]     bits_out,
    output logic [NUM_SLOTS-1:0] events_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out  <= 1'b0;
            code_out   <= '0;
            bits_out   <= '0;
            events_out <= '0;
        end else if (pulse) begin
            valid_out  <= 1'b1;
            code_out   <= code_in;
            bits_out   <= bits_in;
            events_out <= events_in;
        end else begin
            valid_out  <= 1'b0;
            code_out   <= '0;
            bits_out   <= '0;
            events_out <= '0;
        end
    end
endmodule

// File: rtl/mdm_matcher.sv
module mdm_matcher
    import mdm_pkg::*;
#(
    parameter int NUM_SLOTS = 20,
    parameter int NUM_SYS   = 5,
    parameter int PAT_W     = 32,
    parameter int CODE_W    = 5,
    parameter int CNT_W     = 12,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [2:0]           wr_field,
    input  logic [PAT_W-1:0]     wr_data,
    input  logic                 pulse_valid,
    input  logic [CODE_W-1:0]    pulse_code,
    input  logic [PAT_W-1:0]     pulse_bits,
    output logic                 bcast_valid,
    output logic [CODE_W-1:0]    bcast_code,
    output logic [PAT_W-1:0]     bcast_bits,
    output logic [NUM_SLOTS-1:0] bcast_events,
    output logic [NUM_SLOTS-1:0] slot_go,
    output logic [NUM_SLOTS-1:0] slot_done
);
    logic [NUM_SLOTS-1:0] hits;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_slot == SLOT_W'(i));

        mdm_slot #(
            .PAT_W  (PAT_W),
            .CODE_W (CODE_W),
            .CNT_W  (CNT_W),
            .IS_SYS (i < NUM_SYS)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel),
            .wr_field (wr_field),
            .wr_data  (wr_data),
            .pulse    (pulse_valid),
            .pat_code (pulse_code),
            .pat_bits (pulse_bits),
            .hit      (hits[i]),
            .go       (slot_go[i]),
            .done     (slot_done[i])
        );
    end

    mdm_bcast_reg #(
        .PAT_W     (PAT_W),
        .CODE_W    (CODE_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_bcast (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse      (pulse_valid),
        .code_in    (pulse_code),
        .bits_in    (pulse_bits),
        .events_in  (hits),
        .valid_out  (bcast_valid),
        .code_out   (bcast_code),
        .bits_out   (bcast_bits),
        .events_out (bcast_events)
    );

    a_r1_valid_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid |=> bcast_valid);

    a_r1_quiet_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_valid |=> (!bcast_valid && bcast_events == '0));

    a_r6_events_need_go: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> ((bcast_events & ~$past(slot_go)) == '0));

    a_r9_go_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_go & slot_done) == '0);
endmodule

// File: tb/mdm_matcher_tb_top.sv
module mdm_matcher_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 20;
    localparam int NSYS = 5;
    localparam int PW   = 32;
    localparam int CW   = 5;
    localparam int CNTW = 12;
    localparam int SW   = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en;
    logic [SW-1:0] wr_slot;
    logic [2:0] wr_field;
    logic [PW-1:0] wr_data;
    logic pulse_valid;
    logic [CW-1:0] pulse_code;
    logic [PW-1:0] pulse_bits;
    logic bcast_valid;
    logic [CW-1:0] bcast_code;
    logic [PW-1:0] bcast_bits;
    logic [NS-1:0] bcast_events, slot_go, slot_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_matcher #(.NUM_SLOTS(NS), .NUM_SYS(NSYS), .PAT_W(PW), .CODE_W(CW), .CNT_W(CNTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_field(wr_field),
        .wr_data(wr_data), .pulse_valid(pulse_valid), .pulse_code(pulse_code),
        .pulse_bits(pulse_bits), .bcast_valid(bcast_valid), .bcast_code(bcast_code),
        .bcast_bits(bcast_bits), .bcast_events(bcast_events), .slot_go(slot_go),
        .slot_done(slot_done)
    );

    // Requirement model: state 0 Idle, 1 Armed, 2 Retired
    int m_code[NS], m_meas[NS], m_avg[NS], m_state[NS], m_mleft[NS], m_aleft[NS];
    logic [PW-1:0] m_incl[NS], m_excl[NS];
    int checks = 0;
    int errors = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] exp_go();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = (i < NSYS) || (m_state[i] == 1);
        return v;
    endfunction

    function automatic logic [NS-1:0] exp_done();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = (m_state[i] == 2);
        return v;
    endfunction

    task automatic wr(int slot, int field, logic [PW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; pulse_valid = 1'b0;
        wr_slot = SW'(slot); wr_field = 3'(field); wr_data = d;
        if (slot < NS && field <= 5 && (slot < NSYS || m_state[slot] != 1)) begin
            case (field)
                0: m_code[slot] = int'(d[CW-1:0]);
                1: m_incl[slot] = d;
                2: m_excl[slot] = d;
                3: m_meas[slot] = int'(d[CNTW-1:0]);
                4: m_avg[slot]  = int'(d[CNTW-1:0]);
                default: if (slot >= NSYS) begin
                    if (d[0]) begin
                        if (m_meas[slot] != 0) begin
                            m_state[slot] = 1;
                            m_mleft[slot] = m_meas[slot];
                            m_aleft[slot] = (m_avg[slot] == 0) ? 1 : m_avg[slot];
                        end
                    end else begin
                        m_state[slot] = 0;
                    end
                end
            endcase
        end
    endtask

    task automatic pulse(int code, logic [PW-1:0] bits, string req);
        logic [NS-1:0] ev;
        ev = '0;
        @(negedge clk);
        wr_en = 1'b0; pulse_valid = 1'b1; pulse_code = CW'(code); pulse_bits = bits;
        for (int i = 0; i < NS; i++) begin
            if (((i < NSYS) || m_state[i] == 1) && m_code[i] == code &&
                ((bits & m_incl[i]) == m_incl[i]) && ((bits & m_excl[i]) == '0)) begin
                ev[i] = 1'b1;
                if (i >= NSYS) begin
                    if (m_aleft[i] == 1) begin
                        m_aleft[i] = (m_avg[i] == 0) ? 1 : m_avg[i];
                        if (m_mleft[i] == 1) m_state[i] = 2;
                        else m_mleft[i] = m_mleft[i] - 1;
                    end else begin
                        m_aleft[i] = m_aleft[i] - 1;
                    end
                end
            end
        end
        @(negedge clk);
        pulse_valid = 1'b0;
        chk("R1", "valid", 64'(bcast_valid), 64'd1);
        chk(req, "events", 64'(bcast_events), 64'(ev));
        chk("R1", "code", 64'(bcast_code), 64'(code));
        chk("R1", "bits", 64'(bcast_bits), 64'(bits));
        chk(req, "go", 64'(slot_go), 64'(exp_go()));
        chk(req, "done", 64'(slot_done), 64'(exp_done()));
        @(negedge clk);
        chk("R1", "valid low", 64'(bcast_valid), 64'd0);
        chk("R1", "events low", 64'(bcast_events), 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_code[i] = 0; m_meas[i] = 0; m_avg[i] = 0; m_state[i] = 0;
            m_mleft[i] = 0; m_aleft[i] = 0; m_incl[i] = '0; m_excl[i] = '0;
        end
        rst_n = 1'b0; wr_en = 1'b0; wr_slot = '0; wr_field = '0; wr_data = '0;
        pulse_valid = 1'b0; pulse_code = '0; pulse_bits = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "valid", 64'(bcast_valid), 64'd0);
        chk("R11", "events", 64'(bcast_events), 64'd0);
        chk("R11", "go", 64'(slot_go), 64'(exp_go()));
        chk("R11", "done", 64'(slot_done), 64'd0);
        rst_n = 1'b1;
        // R11 config cleared: system slots match code 0 with any bits
        pulse(0, 32'hFFFF_FFFF, "R11");

        // R2 beam code sweep on system slot 0
        wr(0, 0, 32'd7);
        for (int c = 0; c < 32; c++) pulse(c, '0, "R2");

        // R3 R4 R5 mask sweep on system slot 2
        wr(0, 0, 32'd9);
        wr(2, 0, 32'd3);
        for (int inc = 0; inc < 16; inc++) begin
            for (int exc = 0; exc < 16; exc++) begin
                wr(2, 1, PW'(inc));
                wr(2, 2, PW'(exc));
                for (int p = 0; p < 16; p++) pulse(3, PW'(p) | 32'hA5A5_0000, "R3_R4_R5");
            end
        end
        wr(2, 1, '0); wr(2, 2, '0); wr(2, 0, 32'd20);

        // R6 client slot idle does not match
        wr(10, 0, 32'd3); wr(10, 1, 32'd1); wr(10, 3, 32'd0); wr(10, 4, 32'd2);
        pulse(3, 32'd1, "R6");
        // R8 go with zero count is ignored
        wr(10, 5, 32'd1);
        pulse(3, 32'd1, "R8");
        // R9 arm with 3 measurements of 2
        wr(10, 3, 32'd3);
        wr(10, 5, 32'd1);
        wr(10, 0, 32'd4);            // R7 ignored while armed
        wr(10, 1, 32'd0);            // R7 ignored while armed
        pulse(3, 32'd1, "R9");
        pulse(3, 32'd0, "R7_R9");
        pulse(4, 32'd1, "R7");
        wr(10, 5, 32'd0);            // R7 stop ignored while armed
        for (int k = 0; k < 6; k++) pulse(3, 32'd1, "R9");
        // R10 restart from retired, then clear
        wr(10, 3, 32'd1);
        wr(10, 4, 32'd0);
        wr(10, 5, 32'd1);
        pulse(3, 32'd1, "R10");
        pulse(3, 32'd1, "R10");
        wr(10, 5, 32'd0);
        pulse(3, 32'd1, "R10");

        // R7 undefined fields, R12 out of range slot
        wr(11, 0, 32'd6); wr(11, 3, 32'd1);
        wr(11, 6, 32'hFFFF_FFFF);
        wr(11, 7, 32'hFFFF_FFFF);
        wr(25, 0, 32'd6);
        wr(21, 5, 32'd1);
        pulse(6, 32'd0, "R7_R12");
        wr(11, 5, 32'd1);
        pulse(6, 32'd0, "R7");

        // R9 sweep of counts on slot 19 alongside slot 12
        wr(19, 0, 32'd1);
        wr(12, 0, 32'd1); wr(12, 2, 32'd2); wr(12, 3, 32'd2); wr(12, 4, 32'd3);
        wr(12, 5, 32'd1);
        for (int m = 1; m <= 3; m++) begin
            for (int a = 0; a <= 3; a++) begin
                wr(19, 3, PW'(m));
                wr(19, 4, PW'(a));
                wr(19, 5, 32'd1);
                for (int k = 0; k <= m * ((a == 0) ? 1 : a); k++)
                    pulse(1, PW'(k % 3) << 1, "R9");
                wr(19, 5, 32'd0);
            end
        end
        pulse(1, '0, "R10");
        finish_run();
    end
endmodule